// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a system watchdog that runs entirely from its own free-running clock. The system clock can slow or stop, including in power-down, and the watchdog still counts. A prescaler divides the watchdog clock. Each time it wraps, a timer steps up by one. When that timer rolls over from all ones, the block drives a reset pulse of fixed length and raises a system-side reset request. Software keeps the system alive by reloading the timer before it rolls over. The interval is (2^TMR_W − reload) × 2^PRE_W watchdog clock cycles.

Software reaches the block through a small write/read register bus with two locations, selected by `bus_sel`:

- **Control location** (`bus_sel` = 0). One code value, A5h, stops the watchdog and holds its counters at zero. Every other value lets it count.
- **Timer location** (`bus_sel` = 1). A timer write is honoured only when the control location holds the unlock code 5Ah. An honoured write loads the timer, zeroes the prescaler and sets the control location to 00h, so the watchdog stays enabled.

Timer reads return a recent stable snapshot of the counting timer. Enable, reload and snapshot traffic crosses between the two clocks through toggle handshakes and multi-flop synchronizers.

Top module: `wdog_keyed`

## Requirements
- R1: After system reset, the control location reads A5h, the watchdog is halted, and both `wd_pulse` and `sys_rst_o` are low.
- R2: Any byte written to the control location (`bus_sel` = 0) reads back unchanged. Any value other than A5h starts counting.
- R3: While the control location holds A5h, the prescaler and timer are held at zero: the timer reads 0 and no pulse occurs.
- R4: A timer write (`bus_sel` = 1) made while the control location is not 5Ah is ignored. The control location is unchanged and the timer is not reloaded.
- R5: A timer write made while the control location is 5Ah loads the low TMR_W bits of the data into the timer, zeroes the prescaler, and sets the control location to 00h.
- R6: The timer steps once every 2^PRE_W watchdog cycles. Rollover occurs (2^TMR_W − V) × 2^PRE_W watchdog cycles after a load of value V, plus a few cycles of synchronizer latency.
- R7: On rollover, `wd_pulse` goes high for exactly PULSE_TICKS × 2^PRE_W watchdog cycles, and `sys_rst_o` goes high in the system domain during it.
- R8: While the watchdog is counting, reading the timer location returns a recent value of the timer.
- R9: Once started, the reset pulse runs to its full length even if the system clock stops.
- R10: While an earlier accepted timer load is still crossing to the watchdog domain, a further timer write is ignored. The control location keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Location select: 0 control, 1 timer |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data of the selected location |
| wclk | input | 1 | Free-running watchdog clock |
| wrst | input | 1 | Synchronous active-high power-on reset of the watchdog domain |
| wd_pulse | output | 1 | Stretched reset pulse, watchdog domain |
| sys_rst_o | output | 1 | Reset request synchronized to the system clock |

## Verification
Some rules are checked on every cycle:
- In the watchdog domain: the timer only holds, steps by one, reloads or clears; a halt zeroes the counters; a pulse begins only from the all-ones counter state; a running pulse is never cut short.
- In the system domain: a locked timer write leaves both the control location and the load toggle alone; an unlocked write re-arms the control location; reset restores the halt code.

Other behaviours can only be shown by the bench scenarios. These are the exact timeout for every reload value, the pulse length (including with the system clock stopped), the snapshot values seen through reads, and a second load being dropped while the first is still in flight.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] CTL_HALT   = 8'hA5;
  localparam logic [7:0] CTL_UNLOCK = 8'h5A;
  localparam logic [7:0] CTL_ARMED  = 8'h00;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_TMR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/wdk_sync.sv
// Multi-flop synchronizer for levels and toggles entering a clock domain.
module wdk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdk_core.sv
// Watchdog-domain counters: prescaler, timer, pulse stretcher and snapshot.
module wdk_core #(
  parameter int PRE_W       = 11,
  parameter int TMR_W       = 8,
  parameter int PULSE_TICKS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             en_lvl,
  input  logic             ld_tgl,
  input  logic [TMR_W-1:0] ld_val,
  input  logic             snap_tgl,
  output logic             ld_ack,
  output logic             snap_ack,
  output logic [TMR_W-1:0] snap_val,
  output logic             wd_pulse
);
  localparam int PULSE_LEN = PULSE_TICKS * (2 ** PRE_W);
  localparam int PCW       = $clog2(PULSE_LEN + 1);

  logic             en_s, ld_s, snap_s;
  logic [PRE_W-1:0] pre_q;
  logic [TMR_W-1:0] tmr_q, snap_q;
  logic [PCW-1:0]   pcnt_q;
  logic             pulse_q, ld_ack_q, snap_ack_q;
  logic             load, snap_go, pre_wrap, tmr_max;

  wdk_sync #(.W(3), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk (wclk),
    .rst (wrst),
    .d   ({en_lvl, ld_tgl, snap_tgl}),
    .q   ({en_s, ld_s, snap_s})
  );

  assign load     = ld_s ^ ld_ack_q;
  assign snap_go  = snap_s ^ snap_ack_q;
  assign pre_wrap = &pre_q;
  assign tmr_max  = &tmr_q;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      pre_q      <= '0;
      tmr_q      <= '0;
      snap_q     <= '0;
      pcnt_q     <= '0;
      pulse_q    <= 1'b0;
      ld_ack_q   <= 1'b0;
      snap_ack_q <= 1'b0;
    end else begin
      ld_ack_q   <= ld_s;
      snap_ack_q <= snap_s;
      if (snap_go) snap_q <= tmr_q;
      if (pulse_q) begin
        // pulse runs out its full count; counters stay parked at zero
        pre_q <= '0;
        tmr_q <= '0;
        if (pcnt_q == '0) pulse_q <= 1'b0;
        else              pcnt_q  <= pcnt_q - 1'b1;
      end else if (!en_s) begin
        pre_q <= '0;
        tmr_q <= '0;
      end else if (load) begin
        pre_q <= '0;
        tmr_q <= ld_val;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (pre_wrap) begin
          tmr_q <= tmr_q + 1'b1;
          if (tmr_max) begin
            pulse_q <= 1'b1;
            pcnt_q  <= PCW'(PULSE_LEN - 1);
          end
        end
      end
    end
  end

  assign ld_ack   = ld_ack_q;
  assign snap_ack = snap_ack_q;
  assign snap_val = snap_q;
  assign wd_pulse = pulse_q;

  // R3: a halted watchdog holds both counters at zero
  p_halt_clears_r3: assert property (@(posedge wclk) disable iff (wrst)
    !en_s |=> (pre_q == '0 && tmr_q == '0));

  // R6: the timer only holds or advances by one while counting freely
  p_tmr_step_r6: assert property (@(posedge wclk) disable iff (wrst)
    (en_s && !pulse_q && !load) |=>
      (tmr_q == $past(tmr_q) || tmr_q == TMR_W'($past(tmr_q) + 1'b1)));

  // R6: a pulse starts only from the all-ones counter state
  p_rise_at_max_r6: assert property (@(posedge wclk) disable iff (wrst)
    $rose(pulse_q) |-> ((&$past(tmr_q)) && (&$past(pre_q))));

  // R9: a running pulse is never cut short
  p_pulse_hold_r9: assert property (@(posedge wclk) disable iff (wrst)
    (pulse_q && pcnt_q != '0) |=> pulse_q);
endmodule

// File: rtl/wdog_keyed.sv
// System-side registers and clock-domain handshakes of the keyed watchdog.
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int PRE_W       = 11,
  parameter int TMR_W       = 8,
  parameter int PULSE_TICKS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       wclk,
  input  logic       wrst,
  output logic       wd_pulse,
  output logic       sys_rst_o
);
  logic [7:0]       ctl_q, rdata_q;
  logic             en_q, ld_tgl_q, snap_tgl_q;
  logic [TMR_W-1:0] ld_val_q, tmr_rd_q, snap_val;
  logic             ld_ack, snap_ack, ld_ack_s, snap_ack_s, pulse_s;
  logic             busy, ctl_wr, tmr_wr;

  wdk_core #(
    .PRE_W(PRE_W), .TMR_W(TMR_W),
    .PULSE_TICKS(PULSE_TICKS), .SYNC_STAGES(SYNC_STAGES)
  ) u_core (
    .wclk     (wclk),
    .wrst     (wrst),
    .en_lvl   (en_q),
    .ld_tgl   (ld_tgl_q),
    .ld_val   (ld_val_q),
    .snap_tgl (snap_tgl_q),
    .ld_ack   (ld_ack),
    .snap_ack (snap_ack),
    .snap_val (snap_val),
    .wd_pulse (wd_pulse)
  );

  wdk_sync #(.W(3), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ld_ack, snap_ack, wd_pulse}),
    .q   ({ld_ack_s, snap_ack_s, pulse_s})
  );

  assign busy   = ld_tgl_q ^ ld_ack_s;
  assign ctl_wr = bus_we && (bus_sel == SEL_CTL);
  assign tmr_wr = bus_we && (bus_sel == SEL_TMR) && (ctl_q == CTL_UNLOCK) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= CTL_HALT;
      en_q       <= 1'b0;
      ld_tgl_q   <= 1'b0;
      ld_val_q   <= '0;
      snap_tgl_q <= 1'b0;
      tmr_rd_q   <= '0;
      rdata_q    <= '0;
    end else begin
      en_q <= (ctl_q != CTL_HALT);
      if (ctl_wr) begin
        ctl_q <= bus_wdata;
      end else if (tmr_wr) begin
        ctl_q    <= CTL_ARMED;
        ld_val_q <= bus_wdata[TMR_W-1:0];
        ld_tgl_q <= ~ld_tgl_q;
      end
      // snapshot is stable here: the core only rewrites it after a new request
      if (snap_ack_s == snap_tgl_q) begin
        tmr_rd_q   <= snap_val;
        snap_tgl_q <= ~snap_tgl_q;
      end
      rdata_q <= (bus_sel == SEL_TMR) ? 8'(tmr_rd_q) : ctl_q;
    end
  end

  assign bus_rdata = rdata_q;
  assign sys_rst_o = pulse_s;

  // R1: reset restores the halt code
  p_reset_halt_r1: assert property (@(posedge clk)
    rst |=> (ctl_q == CTL_HALT));

  // R4: a locked timer write changes neither control nor load request
  p_locked_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_sel == SEL_TMR && ctl_q != CTL_UNLOCK) |=>
      ($stable(ctl_q) && $stable(ld_tgl_q)));

  // R5: an unlocked idle timer write re-arms control and issues a load
  p_unlock_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_sel == SEL_TMR && ctl_q == CTL_UNLOCK && !busy) |=>
      (ctl_q == CTL_ARMED && ld_tgl_q != $past(ld_tgl_q)));
endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
  localparam int PRE_W = 2;
  localparam int TMR_W = 4;
  localparam int PTK   = 2;
  localparam int TICK  = 2 ** PRE_W;
  localparam int PLEN  = PTK * TICK;
  localparam int SPAN  = 2 ** TMR_W;

  logic clk = 1'b0, wclk = 1'b0, rst = 1'b1, wrst = 1'b1;
  logic bus_we = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic wd_pulse, sys_rst_o;
  bit clk_run = 1'b1;
  bit done = 1'b0;
  int n_chk = 0, n_err = 0;

  wdog_keyed #(.PRE_W(PRE_W), .TMR_W(TMR_W), .PULSE_TICKS(PTK), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wclk(wclk), .wrst(wrst), .wd_pulse(wd_pulse), .sys_rst_o(sys_rst_o)
  );

  always begin #5; if (clk_run) clk = ~clk; end
  always #18.3 wclk = ~wclk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [7:0] v);
    @(negedge clk);
    bus_sel = sel;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge wclk);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wcyc(6);
  endtask

  // counts watchdog cycles until the pulse is seen high
  task automatic wait_pulse(inout int n);
    while (!wd_pulse && n < 3000) begin
      @(negedge wclk);
      n++;
    end
  endtask

  task automatic pulse_len(output int len, output bit saw_sys);
    len = 0; saw_sys = 1'b0;
    while (wd_pulse && len < 1000) begin
      len++;
      if (sys_rst_o) saw_sys = 1'b1;
      @(negedge wclk);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n, len, exp;
    bit saw;

    repeat (4) @(negedge wclk);
    wrst = 1'b0;
    @(negedge clk); rst = 1'b0;
    wcyc(6);

    // R1 reset state
    rd(0, v); chk(v == 8'hA5, "R1", "control after reset", v, 8'hA5);
    chk(!wd_pulse && !sys_rst_o, "R1", "reset outputs", {wd_pulse, sys_rst_o}, 0);
    rd(1, v); chk(v == 8'h00, "R1", "timer after reset", v, 0);

    // R4 locked write while halted: ignored, nothing starts
    wr(1, 8'h03);
    rd(0, v); chk(v == 8'hA5, "R4", "control after locked write", v, 8'hA5);
    n = 0; while (n < 150 && !wd_pulse) begin @(negedge wclk); n++; end
    chk(!wd_pulse, "R4", "no pulse while halted", wd_pulse, 0);

    // R2 / R8 / R6 / R7 free count from zero
    wr(0, 8'h00);
    rd(0, v); chk(v == 8'h00, "R2", "control readback", v, 0);
    n = 1;
    while (n < 30) begin @(negedge wclk); n++; end
    rd(1, v); chk(int'(v) >= (n - 12) / TICK && int'(v) <= n / TICK, "R8", "timer read at 30", v, n / TICK);
    while (n < 50) begin @(negedge wclk); n++; end
    rd(1, v); chk(int'(v) >= (n - 12) / TICK && int'(v) <= n / TICK, "R8", "timer read at 50", v, n / TICK);
    wait_pulse(n);
    exp = SPAN * TICK;
    chk(n >= exp + 1 && n <= exp + 7, "R6", "timeout from enable", n, exp);
    pulse_len(len, saw);
    chk(len == PLEN, "R7", "pulse length", len, PLEN);
    chk(saw, "R7", "system reset request", saw, 1);
    sys_reset();

    // R2 arbitrary nonzero control value also counts
    wr(0, 8'h3C);
    rd(0, v); chk(v == 8'h3C, "R2", "control readback 3C", v, 8'h3C);
    n = 2; wait_pulse(n);
    chk(n >= exp + 1 && n <= exp + 8, "R2", "counting with 3C", n, exp);
    wcyc(PLEN + 1); sys_reset();

    // R4 locked write while counting
    wr(0, 8'h00);
    wr(1, 8'h0C);
    rd(0, v); chk(v == 8'h00, "R4", "control unchanged", v, 0);
    n = 3; wait_pulse(n);
    chk(n >= exp + 1 && n <= exp + 9, "R4", "timer not reloaded", n, exp);
    wcyc(PLEN + 1); sys_reset();

    // R5 / R6 / R7 sweep of every reload value
    for (int val = 0; val < SPAN; val++) begin
      wr(0, 8'h5A);
      wr(1, 8'(val));
      n = 1;
      rd(0, v); chk(v == 8'h00, "R5", "control rearmed", v, 0);
      n += 1;
      wait_pulse(n);
      exp = (SPAN - val) * TICK;
      chk(n >= exp && n <= exp + 7, "R6", "timeout for reload", n, exp);
      pulse_len(len, saw);
      chk(len == PLEN, "R7", "pulse length in sweep", len, PLEN);
      sys_reset();
    end

    // R10 second load while first is in flight
    wr(0, 8'h5A); wr(1, 8'h03); wr(0, 8'h5A); wr(1, 8'h09);
    n = 1;
    rd(0, v); chk(v == 8'h5A, "R10", "second load ignored", v, 8'h5A);
    n += 1;
    wait_pulse(n);
    exp = (SPAN - 3) * TICK - 2;
    chk(n >= exp - 2 && n <= exp + 6, "R10", "timeout follows first load", n, exp);
    wcyc(PLEN + 1); sys_reset();

    // R3 halt clears counters
    wr(0, 8'h00);
    wcyc(40);
    wr(0, 8'hA5);
    wcyc(10);
    rd(1, v); chk(v == 8'h00, "R3", "timer cleared by halt", v, 0);
    n = 0; while (n < 2 * SPAN * TICK && !wd_pulse) begin @(negedge wclk); n++; end
    chk(!wd_pulse, "R3", "no pulse after halt", wd_pulse, 0);

    // R9 pulse completes with system clock stopped
    wr(0, 8'h5A); wr(1, 8'h0E);
    n = 0; wait_pulse(n);
    clk_run = 1'b0;
    pulse_len(len, saw);
    chk(len == PLEN, "R9", "pulse with clock stopped", len, PLEN);
    clk_run = 1'b1;
    sys_reset();
    rd(0, v); chk(v == 8'hA5, "R1", "control after later reset", v, 8'hA5);

    finish_run();
  end
endmodule